// File: doc/BRIEF.md
# 4x-Oversampled 8N1 Serial Engine

This block is the bit-level engine of a simple asynchronous serial port. A 16-bit divisor, supplied as a low byte and a high byte, sets a shared timing tick. The tick fires once every divisor + 1 clocks, so the divisor for a wanted rate is the clock frequency over four times the baud rate, minus one. Four ticks make one bit time. Rates up to 460800 baud are intended, and 115200 baud is the usual setting.

The transmit side takes one byte at a time through a valid/ready handshake. It sends the byte as a fixed frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line rests high between frames.

The receive side synchronises the incoming line and waits for a falling edge. It checks at the second tick that the line is still low, which rejects glitches. It then samples each bit once every four ticks. At the end of the frame it gives a single-cycle strobe with the byte, and raises a frame-error flag when the stop bit is low.

Top module: `x4_serial_core`

## Requirements
- R1: The tick period is {div_hi, div_lo} + 1 clocks, so one bit time on txd is 4 × ({div_hi, div_lo} + 1) clocks; the high byte holds divisor bits 15..8.
- R2: A transmitted frame is a low start bit, then tx_data bits 0 through 7 in that order, then a high stop bit; txd is high whenever no frame is being sent.
- R3: tx_ready is high only while the transmitter is idle. A byte is taken on a cycle where tx_valid and tx_ready are both high. tx_ready is low from the next cycle until the stop bit has ended.
- R4: Every bit of a transmitted frame, including the start bit, stays on txd for exactly four ticks, and txd changes only on a tick.
- R5: A well-formed frame on rxd at the programmed rate produces exactly one rx_valid pulse, one cycle wide, with rx_data equal to the byte sent least significant bit first.
- R6: When the stop bit of a received frame is sampled low, rx_frame_err is high in the same cycle as the rx_valid pulse for that frame. It is never high without rx_valid.
- R7: A low pulse on rxd that is high again before the receiver's mid-start check produces no rx_valid. A following frame is still received correctly.
- R8: A divisor change made while either direction is busy does not alter the bit time of the frame in progress. It applies from the first frame that starts after both directions are idle.
- R9: After reset, txd is high, tx_ready is high, and rx_valid and rx_frame_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo | input | 8 | Divisor bits 7..0 |
| div_hi | input | 8 | Divisor bits 15..8 |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_data and rx_frame_err are valid |
| rx_frame_err | output | 1 | Stop bit of the strobed frame was low |

## Verification
A tick counter or latched divisor that is off by one shows on txd as a start bit whose length differs from 4 × (divisor + 1). That error is visible within the first bit of the first frame, so the bench measures that length exactly. A wrong bit counter or shift direction in either path appears one frame later as a wrong byte, a misplaced stop level or a missing or doubled rx_valid. A receiver that skips its mid-start check shows up only when a short low pulse arrives, as a spurious strobe about one frame time later. A divisor that is latched mid-frame shows as a stretched or shortened bit in the frame during which the divisor was changed.

// File: rtl/x4ser_pkg.sv
package x4ser_pkg;
  // ticks per bit and the counter width needed to count them
  localparam int OVERSAMPLE = 4;
  localparam int OS_CW      = $clog2(OVERSAMPLE);

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_ARM,
    TX_SEND
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/x4ser_tick.sv
module x4ser_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hold_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] div_act_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;

  // the divisor in use is refreshed only while no frame is in flight
  always_comb begin
    tick_o = (cnt_q >= act_q);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    act_d  = hold_i ? act_q : div_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign div_act_o = act_q;
endmodule

// File: rtl/x4ser_tx.sv
module x4ser_tx
  import x4ser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int BIT_CW  = $clog2(FRAME_W);
  localparam logic [BIT_CW-1:0] BIT_LAST  = BIT_CW'(FRAME_W - 1);
  localparam logic [OS_CW-1:0]  TICK_LAST = OS_CW'(OVERSAMPLE - 1);

  tx_state_e          state_q, state_d;
  logic [OS_CW-1:0]   tcnt_q, tcnt_d;
  logic [BIT_CW-1:0]  bitn_q, bitn_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               txd_q, txd_d;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bitn_d  = bitn_q;
    sh_d    = sh_q;
    txd_d   = txd_q;
    case (state_q)
      TX_IDLE: begin
        txd_d = 1'b1;
        if (valid_i) begin
          sh_d    = {1'b1, data_i, 1'b0};
          state_d = TX_ARM;
        end
      end
      TX_ARM: begin
        // wait for a tick so the start bit gets four whole ticks
        if (tick_i) begin
          state_d = TX_SEND;
          tcnt_d  = '0;
          bitn_d  = '0;
          txd_d   = sh_q[0];
        end
      end
      TX_SEND: begin
        if (tick_i) begin
          if (tcnt_q == TICK_LAST) begin
            tcnt_d = '0;
            if (bitn_q == BIT_LAST) begin
              state_d = TX_IDLE;
              txd_d   = 1'b1;
            end else begin
              bitn_d = bitn_q + 1'b1;
              sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
              txd_d  = sh_q[1];
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      tcnt_q  <= '0;
      bitn_q  <= '0;
      sh_q    <= '1;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bitn_q  <= bitn_d;
      sh_q    <= sh_d;
      txd_q   <= txd_d;
    end
  end

  assign ready_o = (state_q == TX_IDLE);
  assign busy_o  = (state_q != TX_IDLE);
  assign txd_o   = txd_q;
endmodule

// File: rtl/x4ser_rx.sv
module x4ser_rx
  import x4ser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o,
  output logic              busy_o
);
  localparam int BIT_CW = $clog2(DATA_W);
  localparam logic [BIT_CW-1:0] BIT_LAST  = BIT_CW'(DATA_W - 1);
  localparam logic [OS_CW-1:0]  TICK_LAST = OS_CW'(OVERSAMPLE - 1);
  localparam logic [OS_CW-1:0]  TICK_MID  = OS_CW'(OVERSAMPLE / 2 - 1);

  logic s1_q, s2_q, s3_q;
  logic fall;

  rx_state_e         state_q, state_d;
  logic [OS_CW-1:0]  tcnt_q, tcnt_d;
  logic [BIT_CW-1:0] bitn_q, bitn_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;

  assign fall = s3_q & ~s2_q;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bitn_d  = bitn_q;
    sh_d    = sh_q;
    dat_d   = dat_q;
    vld_d   = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (fall) begin
          state_d = RX_START;
          tcnt_d  = '0;
        end
      end
      RX_START: begin
        if (tick_i) begin
          if (tcnt_q == TICK_MID) begin
            // still low at mid start: real frame, otherwise a glitch
            if (!s2_q) begin
              state_d = RX_DATA;
              tcnt_d  = '0;
              bitn_d  = '0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick_i) begin
          if (tcnt_q == TICK_LAST) begin
            tcnt_d = '0;
            sh_d   = {s2_q, sh_q[DATA_W-1:1]};
            if (bitn_q == BIT_LAST) state_d = RX_STOP;
            else                    bitn_d  = bitn_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick_i) begin
          if (tcnt_q == TICK_LAST) begin
            state_d = RX_IDLE;
            dat_d   = sh_q;
            vld_d   = 1'b1;
            err_d   = ~s2_q;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      s3_q    <= 1'b1;
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      dat_q   <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      s1_q    <= rxd_i;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bitn_q  <= bitn_d;
      sh_q    <= sh_d;
      dat_q   <= dat_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
    end
  end

  assign data_o  = dat_q;
  assign valid_o = vld_q;
  assign ferr_o  = err_q;
  assign busy_o  = (state_q != RX_IDLE);
endmodule

// File: rtl/x4_serial_core.sv
module x4_serial_core #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W/2-1:0] div_lo,
  input  logic [DIV_W/2-1:0] div_hi,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err
);
  logic             tick;
  logic [DIV_W-1:0] div_act;
  logic             tx_busy, rx_busy;

  x4ser_tick #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_i     ({div_hi, div_lo}),
    .hold_i    (tx_busy | rx_busy),
    .tick_o    (tick),
    .div_act_o (div_act)
  );

  x4ser_tx #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .data_i  (tx_data),
    .valid_i (tx_valid),
    .ready_o (tx_ready),
    .busy_o  (tx_busy),
    .txd_o   (txd)
  );

  x4ser_rx #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .rxd_i   (rxd),
    .data_o  (rx_data),
    .valid_o (rx_valid),
    .ferr_o  (rx_frame_err),
    .busy_o  (rx_busy)
  );
endmodule

// File: rtl/x4ser_checker.sv
module x4ser_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [DIV_W-1:0] div_act,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             txd,
  input logic             rx_valid,
  input logic             rx_frame_err
);
  // back-to-back ticks are only legal with a zero divisor
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick)) |-> (div_act == '0));

  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_txd_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_ferr_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> rx_valid);
endmodule

bind x4_serial_core x4ser_checker #(.DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .div_act      (div_act),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .txd          (txd),
  .rx_valid     (rx_valid),
  .rx_frame_err (rx_frame_err)
);

// File: tb/tb_x4_serial_core.sv
module tb_x4_serial_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] div_lo, div_hi, tx_data, rx_data;
  logic       tx_valid, tx_ready, txd, rxd, rx_valid, rx_frame_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  x4_serial_core dut (
    .clk (clk), .rst_n (rst_n), .div_lo (div_lo), .div_hi (div_hi),
    .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready), .txd (txd),
    .rxd (rxd), .rx_data (rx_data), .rx_valid (rx_valid), .rx_frame_err (rx_frame_err)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    div_lo = 8'(d);
    div_hi = 8'(d >> 8);
  endtask

  // R9: values right after reset
  task automatic t_reset_state();
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = 8'h00; rxd = 1'b1;
    div_lo = 8'd3; div_hi = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1,          "R9 txd after reset",      int'(txd), 1);
    chk(tx_ready == 1'b1,     "R9 tx_ready after reset", int'(tx_ready), 1);
    chk(rx_valid == 1'b0,     "R9 rx_valid after reset", int'(rx_valid), 0);
    chk(rx_frame_err == 1'b0, "R9 frame_err after reset", int'(rx_frame_err), 0);
  endtask

  // send one byte (bit 0 must be 1) and check the waveform on txd;
  // chg_to >= 0 rewrites the divisor 20 cycles into the frame
  task automatic tx_check(input logic [7:0] b, input int d, input int chg_to, input string tag);
    int p = 4 * (d + 1);
    int w = 0;
    set_div(d);
    while (!tx_ready && w < 2000) begin @(negedge clk); w++; end
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready, {tag, " R3 tx_ready low after accept"}, int'(tx_ready), 0);
    fork
      begin
        int lo = 0;
        int wt = 0;
        logic [7:0] got = '0;
        logic stopv;
        while (txd && wt < 4000) begin @(negedge clk); wt++; end
        while (!txd && lo < 5000) begin lo++; @(negedge clk); end
        chk(lo == p, {tag, " R4 start bit length"}, lo, p);
        repeat (p / 2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          got[k] = txd;
          repeat (p) @(negedge clk);
        end
        stopv = txd;
        chk(got == b,     {tag, " R2 data bits lsb first"}, int'(got), int'(b));
        chk(stopv == 1'b1, {tag, " R2 stop bit high"}, int'(stopv), 1);
        chk(!tx_ready,    {tag, " R3 busy during stop"}, int'(tx_ready), 0);
        repeat (p / 2 + 1) @(negedge clk);
        chk(tx_ready,     {tag, " R3 ready after stop"}, int'(tx_ready), 1);
      end
      begin
        if (chg_to >= 0) begin
          repeat (20) @(negedge clk);
          div_lo = 8'(chg_to);
          div_hi = 8'(chg_to >> 8);
        end
      end
    join
  endtask

  // drive one frame into rxd and watch the receive strobe
  task automatic rx_send(input logic [7:0] b, input logic stopv, input int d, input string tag);
    int p = 4 * (d + 1);
    int nv = 0;
    logic [7:0] gd = '0;
    logic gf = 1'b0;
    logic [9:0] fr = {stopv, b, 1'b0};
    set_div(d);
    for (int i = 0; i < 10; i++) begin
      rxd = fr[i];
      repeat (p) begin
        @(negedge clk);
        if (rx_valid) begin nv++; gd = rx_data; gf = rx_frame_err; end
      end
    end
    rxd = 1'b1;
    repeat (3 * p) begin
      @(negedge clk);
      if (rx_valid) begin nv++; gd = rx_data; gf = rx_frame_err; end
    end
    chk(nv == 1,      {tag, " R5 one rx_valid pulse"}, nv, 1);
    chk(gd == b,      {tag, " R5 received byte"}, int'(gd), int'(b));
    chk(gf == !stopv, {tag, " R6 frame error flag"}, int'(gf), int'(!stopv));
  endtask

  // R7: short low pulse is dropped
  task automatic t_glitch();
    int nv = 0;
    set_div(3);
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (8 * 16) begin
      @(negedge clk);
      if (rx_valid) nv++;
    end
    chk(nv == 0, "R7 glitch gives no strobe", nv, 0);
    rx_send(8'h96, 1'b1, 2, "R7 recovery");
  endtask

  initial begin
    t_reset_state();
    tx_check(8'hA5, 3,   -1, "R2");
    tx_check(8'h33, 0,   -1, "R1 div0");
    tx_check(8'h81, 257, -1, "R1 hibyte");
    tx_check(8'hC3, 3,    1, "R8 old rate");
    tx_check(8'h5B, 1,   -1, "R8 new rate");
    rx_send(8'hA5, 1'b1, 3, "R5 d3");
    rx_send(8'h3C, 1'b1, 1, "R5 d1");
    rx_send(8'hF0, 1'b0, 3, "R6");
    t_glitch();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule